// File: doc/BRIEF.md
# Push-Pull PWM Generator with Pulse Steering

This block produces digital pulse-width-modulated drive signals for a push-pull power stage. A free-running counter plays the role of the ramp. The last few clocks of every ramp period are a blanking interval in which no drive output may be high. At the last clock of each period the block takes one sample of the control word. Each period then carries a single on pulse whose width in clocks equals that sampled value, bounded by a soft-start limit and by the length of the unblanked part of the period.

A steering flip-flop toggles once per period and sends the pulses alternately to output A and output B. Each of those outputs therefore runs at half the ramp rate, with a duty below one half over its own period. A combined output, the OR of A and B, restores the pulse train at the full ramp rate.

A shutdown input gates every drive output low immediately. It also discharges the soft-start limit, so after release the duty climbs again from zero. The soft-start limit rises by one count every fixed number of clocks until it reaches the unblanked length.

Top module: `pp_pwm_top`

## Requirements
- R1: The ramp counts 0 to PERIOD-1 and wraps. A period whose sampled duty value is D drives its pulse high for exactly D clocks, at ramp values 0 to D-1, so the duty is D/PERIOD.
- R2: During the last BLANK clocks of every period (ramp value at or above ACTIVE = PERIOD-BLANK), all drive outputs are low.
- R3: The control word is sampled only on the last clock of a period (ramp value PERIOD-1). Changes at any other time have no effect on the pulse in progress.
- R4: Each period holds at most one on pulse (at most one rising edge of out_or).
- R5: Periods are numbered from 0 after reset. Pulses of even-numbered periods appear only on out_a, and pulses of odd-numbered periods appear only on out_b.
- R6: out_or always equals out_a OR out_b.
- R7: While shdn is high, out_a, out_b and out_or are low, starting in the same cycle that shdn rises.
- R8: The soft-start limit is 0 after reset and rises by 1 after every SS_DIV clocks, saturating at ACTIVE. The sampled duty is min(control word, limit, ACTIVE).
- R9: While shdn is high, the soft-start limit is held at 0. After shdn is released, the limit ramps again from 0.
- R10: A control word of 0 produces no pulse. A control word at or above ACTIVE produces a pulse of exactly ACTIVE clocks that never extends into the blanking interval.
- R11: While rst_n is low (synchronous, active low), all outputs are low. The ramp, the pulse latch, the steering flip-flop and the soft-start limit are cleared, so period 0 is steered to out_a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn | input | 1 | Shutdown: forces drive low and clears soft start |
| ctrl | input | CNT_W | Commanded pulse width in clocks |
| out_a | output | 1 | Drive for even-numbered periods |
| out_b | output | 1 | Drive for odd-numbered periods |
| out_or | output | 1 | OR of out_a and out_b |

## Verification
A wrong ramp count shows as a pulse width off by some clocks, or as a high output inside the blanking window, within the first full period. A steering flip-flop that misses a toggle puts two consecutive pulses on the same output, and this is visible within two periods. A soft-start counter with a wrong rate or clear condition makes the first few pulse widths after reset or after shutdown depart from the floor(t/SS_DIV) sequence. A latch that re-arms shows as a second rising edge on out_or within one period.

// File: rtl/pwm_pkg.sv
// Shared types for the push-pull PWM generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pwm_pkg;
    // Which drive output receives the pulse of the current period.
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;
endpackage

// File: rtl/pwm_ramp.sv
// Free-running ramp counter for the PWM generator.
// Counts 0..PERIOD-1 and wraps. Flags the last clock of the period and the
// blanking window (last BLANK clocks).
// Assumes: 0 < BLANK < PERIOD <= 2**CNT_W.
module pwm_ramp #(
    parameter int CNT_W  = 10,
    parameter int PERIOD = 1000,
    parameter int BLANK  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             blank
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] ACT  = CNT_W'(PERIOD - BLANK);

    logic [CNT_W-1:0] cnt_q;

    // Ramp: advance each clock, return to zero after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt   = cnt_q;
    assign wrap  = (cnt_q == LAST);
    assign blank = (cnt_q >= ACT);

    // R1: ramp stays inside its period.
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R1: the count after the last one is zero.
    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_softstart.sv
// Soft-start limit generator.
// The limit rises by one every SS_DIV clocks and saturates at TOP. Reset and
// shutdown hold it, and its divider, at zero.
// Assumes: SS_DIV >= 1, TOP < 2**CNT_W.
module pwm_softstart #(
    parameter int CNT_W  = 10,
    parameter int TOP    = 960,
    parameter int SS_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shdn,
    output logic [CNT_W-1:0] lim
);
    localparam int DIV_W = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SS_DIV - 1);
    localparam logic [CNT_W-1:0] LIM_TOP  = CNT_W'(TOP);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] ss_q;

    // Divider and limit: step the limit on each divider rollover until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || shdn) begin
            div_q <= '0;
            ss_q  <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            if (ss_q < LIM_TOP)
                ss_q <= ss_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign lim = ss_q;

    // R8: the limit never passes the unblanked length.
    a_r8_ss_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ss_q <= LIM_TOP);
    // R8: outside shutdown the limit moves up by at most one per clock.
    a_r8_ss_step: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn |=> (ss_q == $past(ss_q) || ss_q == $past(ss_q) + 1'b1));
    // R9: shutdown discharges the limit.
    a_r9_ss_clear: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> (ss_q == '0));
endmodule

// File: rtl/pwm_pulse.sv
// Per-period pulse latch.
// On the last clock of a period, the duty value is sampled as
// min(ctrl, soft-start limit, ACTIVE) and the latch is armed when that value
// is non-zero. The comparator (ramp reaching the sampled value) ends the
// pulse. After that the latch stays off until the next period.
// Assumes: cnt/wrap/blank come from pwm_ramp with the same parameters.
module pwm_pulse #(
    parameter int CNT_W  = 10,
    parameter int ACTIVE = 960
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic             blank,
    input  logic [CNT_W-1:0] ctrl,
    input  logic [CNT_W-1:0] lim,
    output logic             on
);
    localparam logic [CNT_W-1:0] ACT = CNT_W'(ACTIVE);

    logic [CNT_W-1:0] lvl;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W:0]   cnt_nx;
    logic             on_q;

    // Applied duty: smallest of command, soft-start limit and unblanked length.
    always_comb begin
        lvl = ctrl;
        if (lim < lvl) lvl = lim;
        if (ACT < lvl) lvl = ACT;
    end

    assign cnt_nx = {1'b0, cnt} + 1'b1;

    // Latch: arm at period start, end when the next ramp value reaches the duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            on_q   <= 1'b0;
        end else if (wrap) begin
            duty_q <= lvl;
            on_q   <= (lvl != '0);
        end else if (on_q && (cnt_nx >= {1'b0, duty_q})) begin
            on_q   <= 1'b0;
        end
    end

    assign on = on_q;

    // R2: no pulse inside the blanking window.
    a_r2_blank_low: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !on_q);
    // R4: once off inside a period, the latch stays off until the period ends.
    a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_q && !wrap) |=> !on_q);
    // R3: the sampled duty moves only at the period boundary.
    a_r3_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_q));
    // R10: a zero command yields an idle next period.
    a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctrl == '0) |=> !on_q);
endmodule

// File: rtl/pwm_steer.sv
// Pulse steering and output gating.
// A toggle flip-flop flips at every period boundary and selects out_a or out_b
// for the pulse. Shutdown gates both outputs combinationally.
// Assumes: on is the registered pulse from pwm_pulse.
module pwm_steer
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic on,
    input  logic shdn,
    output logic out_a,
    output logic out_b,
    output logic out_or
);
    side_e side_q;
    logic  drive;

    // Steering flip-flop: alternate the target output every period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            side_q <= SIDE_A;
        else if (wrap)
            side_q <= (side_q == SIDE_A) ? SIDE_B : SIDE_A;
    end

    assign drive  = on & ~shdn;
    assign out_a  = drive & (side_q == SIDE_A);
    assign out_b  = drive & (side_q == SIDE_B);
    assign out_or = out_a | out_b;

    // R5: the steering flips at each period boundary.
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (side_q != $past(side_q)));
    // R5: and only there.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(side_q));
    // R5: both push-pull outputs never overlap.
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_a, out_b}));
endmodule

// File: rtl/pp_pwm_top.sv
// Push-pull PWM generator top.
// Ties the ramp, soft start, pulse latch and steering together.
// Assumes: 0 < BLANK < PERIOD <= 2**CNT_W, SS_DIV >= 1, ctrl synchronous to clk.
module pp_pwm_top #(
    parameter int CNT_W  = 10,
    parameter int PERIOD = 1000,
    parameter int BLANK  = 40,
    parameter int SS_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shdn,
    input  logic [CNT_W-1:0] ctrl,
    output logic             out_a,
    output logic             out_b,
    output logic             out_or
);
    localparam int ACTIVE = PERIOD - BLANK;

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             blank;
    logic [CNT_W-1:0] lim;
    logic             on;

    pwm_ramp #(.CNT_W(CNT_W), .PERIOD(PERIOD), .BLANK(BLANK)) u_ramp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .blank(blank));

    pwm_softstart #(.CNT_W(CNT_W), .TOP(ACTIVE), .SS_DIV(SS_DIV)) u_ss (
        .clk(clk), .rst_n(rst_n), .shdn(shdn), .lim(lim));

    pwm_pulse #(.CNT_W(CNT_W), .ACTIVE(ACTIVE)) u_pulse (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .blank(blank),
        .ctrl(ctrl), .lim(lim), .on(on));

    pwm_steer u_steer (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .on(on), .shdn(shdn),
        .out_a(out_a), .out_b(out_b), .out_or(out_or));

    // R7: shutdown keeps the combined drive quiet.
    a_r7_shdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |-> !out_or);
    // R2: the combined output is low during blanking.
    a_r2_or_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !out_or);
endmodule

// File: tb/tb_pp_pwm_top.sv
`timescale 1ns/1ps
// Directed bench for pp_pwm_top; one task per scenario.
module tb_pp_pwm_top;
    localparam int CW  = 6;
    localparam int P   = 32;
    localparam int BLK = 4;
    localparam int ACT = P - BLK;
    localparam int SSD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shdn = 1'b0;
    logic [CW-1:0] ctrl = '0;
    logic          out_a, out_b, out_or;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int tc = 0;
    int pidx = 0;

    always #2.5 clk = ~clk;

    pp_pwm_top #(.CNT_W(CW), .PERIOD(P), .BLANK(BLK), .SS_DIV(SSD)) dut (
        .clk(clk), .rst_n(rst_n), .shdn(shdn), .ctrl(ctrl),
        .out_a(out_a), .out_b(out_b), .out_or(out_or));

    // Bench ramp position and period number, from R1/R5.
    always @(posedge clk) begin
        if (!rst_n) begin
            tc <= 0; pidx <= 0;
        end else if (tc == P - 1) begin
            tc <= 0; pidx <= pidx + 1;
        end else begin
            tc <= tc + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Observe one whole period starting at ramp 0.
    task automatic meas(output int wa, output int wb, output int rises,
                        output int blank_hi, output int or_mis, output int side);
        int prev;
        while (tc != 0) @(negedge clk);
        side = pidx % 2;
        wa = 0; wb = 0; rises = 0; blank_hi = 0; or_mis = 0; prev = 0;
        for (int i = 0; i < P; i++) begin
            if (out_a) wa++;
            if (out_b) wb++;
            if (out_or != (out_a | out_b)) or_mis++;
            if (out_or && prev == 0) rises++;
            prev = int'(out_or);
            if (i >= ACT && out_or) blank_hi++;
            @(negedge clk);
        end
    endtask

    // Check a period's pulse lands on the right side with the right width.
    task automatic chk_side(input string tag, input int wa, input int wb,
                            input int side, input int exp);
        chk({tag, " R5 side A width"}, wa, (side == 0) ? exp : 0);
        chk({tag, " R5 side B width"}, wb, (side == 1) ? exp : 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 outputs low in reset", int'(out_a | out_b | out_or), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_softstart();
        int wa, wb, r, bh, om, sd, exp, lim;
        for (int k = 0; k < 5; k++) begin
            meas(wa, wb, r, bh, om, sd);
            chk("R11 period number parity", sd, k % 2);
            lim = (k == 0) ? 0 : (P * k - 1) / SSD;
            if (lim > ACT) lim = ACT;
            exp = (lim < 28) ? lim : 28;
            chk_side("R8 soft start", wa, wb, sd, exp);
        end
    endtask

    task automatic t_linear(input int v);
        int wa, wb, r, bh, om, sd;
        ctrl = CW'(v);
        meas(wa, wb, r, bh, om, sd);
        meas(wa, wb, r, bh, om, sd);
        chk_side("R1 linear duty", wa, wb, sd, v);
        chk("R10 R4 pulse count", r, (v == 0) ? 0 : 1);
        chk("R6 or matches", om, 0);
    endtask

    task automatic t_cap(input int v);
        int wa, wb, r, bh, om, sd;
        ctrl = CW'(v);
        meas(wa, wb, r, bh, om, sd);
        meas(wa, wb, r, bh, om, sd);
        chk("R10 capped width", wa + wb, ACT);
        chk("R2 blank low", bh, 0);
    endtask

    task automatic t_alternate();
        int wa1, wb1, r1, bh1, om1, s1, wa2, wb2, r2, bh2, om2, s2;
        ctrl = CW'(10);
        meas(wa1, wb1, r1, bh1, om1, s1);
        meas(wa1, wb1, r1, bh1, om1, s1);
        meas(wa2, wb2, r2, bh2, om2, s2);
        chk("R5 alternating sides", int'(s1 != s2), 1);
        chk_side("R5 first", wa1, wb1, s1, 10);
        chk_side("R5 second", wa2, wb2, s2, 10);
        chk("R6 or matches", om1 + om2, 0);
    endtask

    task automatic t_midchange();
        int w, r, prev, wa, wb, bh, om, sd;
        ctrl = CW'(20);
        meas(wa, wb, r, bh, om, sd);
        while (tc != 0) @(negedge clk);
        w = 0; r = 0; prev = 0;
        for (int i = 0; i < P; i++) begin
            if (i == 5) ctrl = CW'(3);
            if (i == 9) ctrl = CW'(0);
            if (i == 12) ctrl = CW'(25);
            #1;
            if (out_or) w++;
            if (out_or && prev == 0) r++;
            prev = int'(out_or);
            @(negedge clk);
        end
        chk("R3 width ignores mid-period change", w, 20);
        chk("R4 single pulse", r, 1);
        meas(wa, wb, r, bh, om, sd);
        chk("R3 new value at next period", wa + wb, 25);
    endtask

    task automatic t_shutdown();
        int w, wa, wb, r, bh, om, sd;
        ctrl = CW'(28);
        meas(wa, wb, r, bh, om, sd);
        while (tc != 0) @(negedge clk);
        w = 0;
        for (int i = 0; i < P; i++) begin
            if (i == 3) shdn = 1'b1;
            #1;
            if (out_a | out_b | out_or) w++;
            @(negedge clk);
        end
        chk("R7 shutdown cuts pulse", w, 3);
        meas(wa, wb, r, bh, om, sd);
        chk("R7 idle in shutdown", wa + wb, 0);
        shdn = 1'b0;
        meas(wa, wb, r, bh, om, sd);
        chk("R9 first period after release", wa + wb, 0);
        meas(wa, wb, r, bh, om, sd);
        chk("R9 soft start restarts", wa + wb, (P - 1) / SSD);
        meas(wa, wb, r, bh, om, sd);
        chk("R9 soft start second step", wa + wb, (2 * P - 1) / SSD);
    endtask

    initial begin
        ctrl = CW'(28);
        t_reset();
        t_softstart();
        t_linear(5);
        t_linear(13);
        t_linear(0);
        t_cap(50);
        t_cap(ACT);
        t_alternate();
        t_midchange();
        t_shutdown();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule